// File: doc/BRIEF.md
# Adaptive FIR Filter with Trained Error Canceller

This block is a streaming LMS adaptive FIR filter paired with a short second adaptive filter, the canceller. The canceller learns a statistical estimate of the error in the main filter's output from the same input samples, and that estimate is subtracted from the result. A phase controller steps through three modes in a fixed order: main-filter training, canceller training, and steady-state filtering. A single weight-update engine serves both coefficient sets, one at a time.

Samples arrive with a valid strobe, together with a training target sample. A start pulse launches a calibration, or reruns it, from the beginning. Each canceller tap can be switched off individually through an enable mask. An injection input adds a value to the main filter output during canceller training and filtering. A bench uses it to stand in for the timing errors that an aggressively scaled supply would cause.

All arithmetic is signed and fixed point. Coefficients have FRAC fractional bits. Filter sums are shifted right arithmetically by FRAC and clipped to OW bits. The LMS step is the product error × sample, shifted right arithmetically (floor) by MU_SHIFT and added to the weight. The new weight is clipped to CW bits.

Top module: `adf_aec_filter`

## Requirements
- R1: After reset, the phase output reads 0 (idle), out_valid_o and calibrated_o are low, and all weights are zero. In idle, samples are filtered with no adaptation and no injection, so the output is the main filter output.
- R2: In phase 1 (main training), each sample updates every main weight k with the error target minus main output, times the sample delayed k. The output is the plain main filter output, and inj_i has no effect on the output.
- R3: The phase output moves 0→1 on start_i, then 1→2 after exactly CAL1_LEN valid samples, then 2→3 after exactly CAL2_LEN valid samples. The codes are 0 idle, 1 main training, 2 canceller training, 3 filtering.
- R4: In phase 2, the main weights are frozen. The canceller weights adapt on the error (main output + injection − target − estimate), and the output is main output + injection − estimate.
- R5: calibrated_o is high for exactly one cycle, the first cycle in which the phase output reads 3.
- R6: In phase 3, no weight changes, the phase stays 3 until start_i, and the output is main output + injection − estimate.
- R7: Bit k of tap_en_i enables the canceller tap that sees the sample delayed k. A disabled tap adds zero to the estimate and its weight is not updated.
- R8: Filter outputs, errors and corrected outputs clip to the signed OW-bit range, and weights clip to the signed CW-bit range. None of them wraps.
- R9: start_i in any phase clears both weight sets and returns the block to phase 1. The sample delay line is kept.
- R10: Each valid input sample yields exactly one out_valid_o pulse two clock edges after it is presented. Gaps in in_valid_i produce gaps in the output.
- R11: The weight step equals floor((error × sample) / 2^MU_SHIFT). Each sample's update is visible to the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or rerun calibration from phase 1 |
| in_valid_i | input | 1 | Input sample strobe |
| x_i | input | DW | Input sample, signed |
| d_i | input | DW | Training target sample, signed |
| inj_i | input | DW | Error value added to the main output in phases 2 and 3, signed |
| tap_en_i | input | NT_C | Canceller tap enables; bit k = delay k |
| out_valid_o | output | 1 | Output sample strobe |
| y_o | output | OW | Corrected output, signed |
| phase_o | output | 2 | Current phase code |
| calibrated_o | output | 1 | One-cycle pulse on entry to phase 3 |

## Verification
The bench goes after the phase boundaries, sample by sample. A controller that is off by one would adapt one sample too many or too few, and the outputs would drift from the reference right after the boundary. Injection is driven during main training. A design that applied it there would corrupt the main weights, and the phase-1 outputs would differ. The canceller is trained with one tap masked and then enabled in filtering. A design that updated masked taps would cancel the injected error, although that tap should still hold zero. A full-scale alternating input drives the LMS loop unstable. A design that wrapped instead of clipping would produce outputs far from the rails that the reference reaches.

// File: rtl/adf_pkg.sv
`timescale 1ns/1ps
package adf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PCAL = 2'd1,
    PH_CCAL = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  // clip to signed w-bit range
  function automatic longint clip(input longint v, input int w);
    longint hi, lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/adf_tapline.sv
`timescale 1ns/1ps
module adf_tapline #(
  parameter int DW = 12,
  parameter int NT = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] tap_o [NT]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NT; k++) tap_o[k] <= '0;
    end else if (shift_i) begin
      tap_o[0] <= x_i;
      for (int k = 1; k < NT; k++) tap_o[k] <= tap_o[k-1];
    end
  end
endmodule

// File: rtl/adf_fir.sv
`timescale 1ns/1ps
module adf_fir #(
  parameter int DW   = 12,
  parameter int CW   = 16,
  parameter int OW   = 14,
  parameter int FRAC = 14,
  parameter int NT   = 4
) (
  input  logic signed [DW-1:0] tap_i [NT],
  input  logic signed [CW-1:0] w_i   [NT],
  input  logic [NT-1:0]        en_i,
  output logic signed [OW-1:0] y_o
);
  localparam int PW = DW + CW;
  localparam int AW = PW + $clog2(NT) + 1;

  logic signed [PW-1:0] pr [NT];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] shf;

  for (genvar k = 0; k < NT; k++) begin : g_mul
    assign pr[k] = tap_i[k] * w_i[k];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++)
      if (en_i[k]) acc = acc + AW'(pr[k]);
    shf = acc >>> FRAC;
    y_o = OW'(adf_pkg::clip(longint'(shf), OW));
  end
endmodule

// File: rtl/adf_lms_engine.sv
`timescale 1ns/1ps
module adf_lms_engine #(
  parameter int DW       = 12,
  parameter int CW       = 16,
  parameter int OW       = 14,
  parameter int MU_SHIFT = 8,
  parameter int NT       = 4
) (
  input  logic signed [CW-1:0] w_i [NT],
  input  logic signed [DW-1:0] x_i [NT],
  input  logic signed [OW-1:0] err_i,
  input  logic [NT-1:0]        en_i,
  output logic signed [CW-1:0] w_o [NT]
);
  localparam int PW = OW + DW;
  localparam int SW = ((PW > CW) ? PW : CW) + 1;

  for (genvar k = 0; k < NT; k++) begin : g_lane
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] stp;
    logic signed [SW-1:0] sum;
    assign prod = err_i * x_i[k];
    assign stp  = prod >>> MU_SHIFT;
    assign sum  = SW'(stp) + SW'(w_i[k]);
    assign w_o[k] = en_i[k] ? CW'(adf_pkg::clip(longint'(sum), CW)) : w_i[k];
  end
endmodule

// File: rtl/adf_phase_ctrl.sv
`timescale 1ns/1ps
module adf_phase_ctrl import adf_pkg::*; #(
  parameter int CAL1_LEN = 4000,
  parameter int CAL2_LEN = 650
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   smp_i,
  output phase_e phase_o,
  output logic   cal_o
);
  localparam int MAXL = (CAL1_LEN > CAL2_LEN) ? CAL1_LEN : CAL2_LEN;
  localparam int CNTW = $clog2(MAXL + 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      cnt_q   <= '0;
      cal_o   <= 1'b0;
    end else begin
      cal_o <= 1'b0;
      if (start_i) begin
        phase_o <= PH_PCAL;
        cnt_q   <= '0;
      end else if (smp_i) begin
        unique case (phase_o)
          PH_PCAL: if (cnt_q == CNTW'(CAL1_LEN - 1)) begin
            phase_o <= PH_CCAL;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
          PH_CCAL: if (cnt_q == CNTW'(CAL2_LEN - 1)) begin
            phase_o <= PH_RUN;
            cnt_q   <= '0;
            cal_o   <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r5_cal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> (phase_o == PH_RUN) && ($past(phase_o) == PH_CCAL));
  a_r6_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_RUN) && !start_i |=> (phase_o == PH_RUN) && !cal_o);
  a_r9_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> phase_o == PH_PCAL);
  a_r3_pcal_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_PCAL) && !start_i |=> (phase_o == PH_PCAL) || (phase_o == PH_CCAL));
  a_r3_idle_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_IDLE) && !start_i |=> phase_o == PH_IDLE);
endmodule

// File: rtl/adf_aec_filter.sv
`timescale 1ns/1ps
module adf_aec_filter import adf_pkg::*; #(
  parameter int DW       = 12,
  parameter int CW       = 16,
  parameter int FRAC     = 14,
  parameter int NT_P     = 4,
  parameter int NT_C     = 2,
  parameter int MU_SHIFT = 8,
  parameter int CAL1_LEN = 4000,
  parameter int CAL2_LEN = 650,
  parameter int OW       = DW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] d_i,
  input  logic signed [DW-1:0] inj_i,
  input  logic [NT_C-1:0]      tap_en_i,
  output logic                 out_valid_o,
  output logic signed [OW-1:0] y_o,
  output logic [1:0]           phase_o,
  output logic                 calibrated_o
);
  phase_e phase;
  logic   s1_v, upd_p, upd_c, inj_on;
  logic signed [DW-1:0] d_q, inj_q;
  logic signed [DW-1:0] taps  [NT_P];
  logic signed [DW-1:0] tap_c [NT_C];
  logic signed [CW-1:0] w_p [NT_P];
  logic signed [CW-1:0] w_c [NT_C];
  logic signed [CW-1:0] eng_w_in  [NT_P];
  logic signed [CW-1:0] eng_w_out [NT_P];
  logic [NT_P-1:0]      eng_en;
  logic signed [OW-1:0] y_p, e_hat, eng_err, y_nxt;

  // stage 1: capture sample side data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v  <= 1'b0;
      d_q   <= '0;
      inj_q <= '0;
    end else begin
      s1_v <= in_valid_i;
      if (in_valid_i) begin
        d_q   <= d_i;
        inj_q <= inj_i;
      end
    end
  end

  adf_tapline #(.DW(DW), .NT(NT_P)) u_taps (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(in_valid_i), .x_i(x_i), .tap_o(taps)
  );

  for (genvar k = 0; k < NT_C; k++) begin : g_ctap
    assign tap_c[k] = taps[k];
  end

  adf_fir #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC), .NT(NT_P)) u_fir_p (
    .tap_i(taps), .w_i(w_p), .en_i({NT_P{1'b1}}), .y_o(y_p)
  );

  adf_fir #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC), .NT(NT_C)) u_fir_c (
    .tap_i(tap_c), .w_i(w_c), .en_i(tap_en_i), .y_o(e_hat)
  );

  adf_phase_ctrl #(.CAL1_LEN(CAL1_LEN), .CAL2_LEN(CAL2_LEN)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .smp_i(s1_v),
    .phase_o(phase), .cal_o(calibrated_o)
  );

  // shared update engine: bank select by phase
  for (genvar k = 0; k < NT_P; k++) begin : g_sel
    if (k < NT_C) begin : g_both
      assign eng_w_in[k] = (phase == PH_PCAL) ? w_p[k] : w_c[k];
    end else begin : g_ponly
      assign eng_w_in[k] = (phase == PH_PCAL) ? w_p[k] : '0;
    end
  end
  assign eng_en = (phase == PH_PCAL) ? {NT_P{1'b1}} : NT_P'(tap_en_i);

  adf_lms_engine #(.DW(DW), .CW(CW), .OW(OW), .MU_SHIFT(MU_SHIFT), .NT(NT_P)) u_lms (
    .w_i(eng_w_in), .x_i(taps), .err_i(eng_err), .en_i(eng_en), .w_o(eng_w_out)
  );

  assign inj_on = (phase == PH_CCAL) || (phase == PH_RUN);
  assign upd_p  = s1_v && (phase == PH_PCAL);
  assign upd_c  = s1_v && (phase == PH_CCAL);

  always_comb begin
    longint yp, ype, eh, dd;
    yp  = longint'(y_p);
    eh  = longint'(e_hat);
    dd  = longint'(d_q);
    ype = clip(yp + (inj_on ? longint'(inj_q) : 64'sd0), OW);
    if (phase == PH_PCAL) eng_err = OW'(clip(dd - yp, OW));
    else                  eng_err = OW'(clip(ype - dd - eh, OW));
    y_nxt = inj_on ? OW'(clip(ype - eh, OW)) : y_p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NT_P; k++) w_p[k] <= '0;
      for (int k = 0; k < NT_C; k++) w_c[k] <= '0;
    end else if (start_i) begin
      for (int k = 0; k < NT_P; k++) w_p[k] <= '0;
      for (int k = 0; k < NT_C; k++) w_c[k] <= '0;
    end else begin
      if (upd_p) for (int k = 0; k < NT_P; k++) w_p[k] <= eng_w_out[k];
      if (upd_c) for (int k = 0; k < NT_C; k++) w_c[k] <= eng_w_out[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y_o         <= '0;
    end else begin
      out_valid_o <= s1_v;
      if (s1_v) y_o <= y_nxt;
    end
  end

  assign phase_o = phase;

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);

  for (genvar k = 0; k < NT_P; k++) begin : g_ap
    a_r4_primary_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase != PH_PCAL) && !start_i |=> $stable(w_p[k]));
  end
  for (genvar k = 0; k < NT_C; k++) begin : g_ac
    a_r7_masked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tap_en_i[k] && !start_i |=> $stable(w_c[k]));
    a_r6_run_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase == PH_RUN) && !start_i |=> $stable(w_c[k]));
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (w_c[k] == '0));
  end
endmodule

// File: tb/sim_adf_aec_filter.sv
`timescale 1ns/1ps
module sim_adf_aec_filter;
  localparam int DW = 12, CW = 16, FRAC = 14, NT_P = 4, NT_C = 2;
  localparam int MU = 8, CAL1 = 4000, CAL2 = 650, OW = DW + 2;
  localparam longint YMAX = (64'sd1 <<< (OW - 1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] x = '0, d = '0, inj = '0;
  logic [NT_C-1:0] mask = '1;
  logic out_valid, calibrated;
  logic signed [OW-1:0] y;
  logic [1:0] phase;

  always #5 clk = ~clk;

  adf_aec_filter #(.DW(DW), .CW(CW), .FRAC(FRAC), .NT_P(NT_P), .NT_C(NT_C),
    .MU_SHIFT(MU), .CAL1_LEN(CAL1), .CAL2_LEN(CAL2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_valid_i(in_valid),
    .x_i(x), .d_i(d), .inj_i(inj), .tap_en_i(mask),
    .out_valid_o(out_valid), .y_o(y), .phase_o(phase), .calibrated_o(calibrated)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string sec_tag = "";

  // reference model state
  longint wp [NT_P], wc [NT_C], tl [NT_P];
  int m_ph = 0, m_cnt = 0;
  // expectation pipeline (index 1 = visible now)
  bit p_v [2], p_c [2];
  longint p_y [2], p_d [2];
  int p_ph [2];
  int skip_ph = 0;
  // stimulus state
  int unsigned seed = 32'h1234_5678;
  longint xh1 = 0;
  int smp_idx = 0;
  // measurement
  longint m_acc = 0; int m_n = 0, rails = 0, cal_pulses = 0;

  function automatic longint clipv(input longint v, input int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic string ph_tag(input int p);
    case (p)
      0: return "R1";
      1: return "R2 R11";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_start();
    foreach (wp[k]) wp[k] = 0;
    foreach (wc[k]) wc[k] = 0;
    m_ph = 1; m_cnt = 0;
  endtask

  task automatic model_sample(input longint xv, input longint dv, input longint iv,
                              output longint yo, output bit cal);
    longint acc, yp, eh, ype, e1, e2;
    bit on;
    for (int k = NT_P - 1; k > 0; k--) tl[k] = tl[k-1];
    tl[0] = xv;
    acc = 0;
    for (int k = 0; k < NT_P; k++) acc += wp[k] * tl[k];
    yp = clipv(acc >>> FRAC, OW);
    acc = 0;
    for (int k = 0; k < NT_C; k++) if (mask[k]) acc += wc[k] * tl[k];
    eh = clipv(acc >>> FRAC, OW);
    on = (m_ph >= 2);
    ype = clipv(yp + (on ? iv : 0), OW);
    e1 = clipv(dv - yp, OW);
    e2 = clipv(ype - dv - eh, OW);
    yo = on ? clipv(ype - eh, OW) : yp;
    cal = 0;
    if (m_ph == 1) begin
      for (int k = 0; k < NT_P; k++) wp[k] = clipv(wp[k] + ((e1 * tl[k]) >>> MU), CW);
      if (m_cnt == CAL1 - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
    end else if (m_ph == 2) begin
      for (int k = 0; k < NT_C; k++)
        if (mask[k]) wc[k] = clipv(wc[k] + ((e2 * tl[k]) >>> MU), CW);
      if (m_cnt == CAL2 - 1) begin m_ph = 3; m_cnt = 0; cal = 1; end else m_cnt++;
    end
  endtask

  task automatic check_now();
    string t;
    t = {ph_tag(p_ph[1]), (sec_tag != "") ? " " : "", sec_tag};
    chk(out_valid == p_v[1], "R10 out_valid", longint'(out_valid), longint'(p_v[1]));
    if (p_v[1] && out_valid) begin
      chk(longint'(y) == p_y[1], t, longint'(y), p_y[1]);
      m_acc += (longint'(y) > p_d[1]) ? longint'(y) - p_d[1] : p_d[1] - longint'(y);
      m_n++;
      if (longint'(y) == YMAX || longint'(y) == -YMAX - 1) rails++;
    end
    chk(calibrated == p_c[1], "R5 calibrated", longint'(calibrated), longint'(p_c[1]));
    if (calibrated) cal_pulses++;
    if (skip_ph > 0) skip_ph--;
    else chk(int'(phase) == p_ph[1], "R3 phase", longint'(phase), longint'(p_ph[1]));
  endtask

  // one clock: check, then drive
  task automatic step(input bit v, input bit st, input longint xv, input longint dv,
                      input longint iv);
    longint yo; bit cal;
    @(negedge clk);
    check_now();
    in_valid = v; start = st;
    x = DW'(xv); d = DW'(dv); inj = DW'(iv);
    yo = 0; cal = 0;
    if (st) begin model_start(); skip_ph = 1; end
    if (v) model_sample(xv, dv, iv, yo, cal);
    p_v[1] = p_v[0]; p_y[1] = p_y[0]; p_c[1] = p_c[0]; p_ph[1] = p_ph[0]; p_d[1] = p_d[0];
    p_v[0] = v; p_y[0] = yo; p_c[0] = cal; p_ph[0] = m_ph; p_d[0] = dv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic do_start();
    idle(2);
    step(0, 1, 0, 0, 0);
  endtask

  // random samples; target = x/2 + x1/4, injection = x1/8
  task automatic run(input int n);
    int sent = 0;
    while (sent < n) begin
      smp_idx++;
      if (smp_idx % 7 == 0) step(0, 0, 0, 0, 0);
      else begin
        longint xv, dv, iv;
        seed = seed * 32'd1664525 + 32'd1013904223;
        xv = longint'(seed[25:16]) - 512;
        dv = (xv >>> 1) + (xh1 >>> 2);
        iv = xh1 >>> 3;
        xh1 = xv;
        step(1, 0, xv, dv, iv);
        sent++;
      end
    end
  endtask

  task automatic meas_reset();
    m_acc = 0; m_n = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    foreach (tl[k]) tl[k] = 0;
    foreach (wp[k]) wp[k] = 0;
    foreach (wc[k]) wc[k] = 0;
    for (int i = 0; i < 2; i++) begin p_v[i] = 0; p_y[i] = 0; p_c[i] = 0; p_ph[i] = 0; p_d[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(phase == 2'd0, "R1 phase in reset", longint'(phase), 0);
    chk(calibrated == 1'b0, "R1 calibrated in reset", longint'(calibrated), 0);
    rst_n = 1'b1;
    // R1: idle filtering with zero weights, no adaptation
    run(10);
    idle(2);
    chk(phase == 2'd0, "R1 idle without start", longint'(phase), 0);

    // first calibration, all canceller taps on
    mask = 2'b11;
    do_start();
    run(CAL1);
    idle(2);
    chk(phase == 2'd2, "R3 phase 2 after CAL1_LEN samples", longint'(phase), 2);
    meas_reset();
    run(CAL2);
    idle(2);
    chk(phase == 2'd3, "R3 phase 3 after CAL2_LEN samples", longint'(phase), 3);
    chk(cal_pulses == 1, "R5 single calibrated pulse", cal_pulses, 1);
    meas_reset();
    run(200);
    idle(2);
    chk(m_acc < 8 * m_n, "R6 corrected error small in phase 3", m_acc / m_n, 8);
    chk(phase == 2'd3, "R6 phase holds", longint'(phase), 3);

    // R7: disable delay-1 tap in phase 3 -> injection no longer cancelled
    mask = 2'b01;
    sec_tag = "R7";
    meas_reset();
    run(200);
    idle(2);
    chk(m_acc > 16 * m_n, "R7 masked tap removes cancellation", m_acc / m_n, 16);

    // R9: recalibrate from phase 3, canceller trained with tap 1 masked
    sec_tag = "R9";
    do_start();
    idle(1);
    chk(phase == 2'd1, "R9 back to phase 1", longint'(phase), 1);
    run(3);
    idle(2);
    sec_tag = "R7";
    run(CAL1 + CAL2);
    idle(2);
    chk(phase == 2'd3, "R3 second calibration done", longint'(phase), 3);
    chk(cal_pulses == 2, "R5 second calibrated pulse", cal_pulses, 2);
    mask = 2'b11;
    meas_reset();
    run(200);
    idle(2);
    chk(m_acc > 16 * m_n, "R7 untrained masked tap stays zero", m_acc / m_n, 16);

    // R8: full-scale alternating input drives LMS unstable, must clip
    sec_tag = "R8";
    do_start();
    rails = 0;
    for (int i = 0; i < 120; i++)
      step(1, 0, (i % 2 == 0) ? 2047 : -2048, 2047, 0);
    idle(2);
    chk(rails > 0, "R8 outputs reach clip rails", rails, 1);
    sec_tag = "";
    do_start();
    idle(3);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    finish_run();
  end
endmodule